// File: doc/BRIEF.md
# Masked-Window Memory Chip-Select Decoder

This block watches a stream of 32-bit memory access addresses and drives an active-low chip-select strobe for one device mapped into a programmable window. Software configures two 32-bit registers through a small register port that has byte-wide write strobes: a window base address and a decode control word. The control word holds a global decode enable, separate read and write qualifiers, and a 19-bit compare mask that covers address bits 31:13.

Each address bit in the range 31:13 whose mask bit is set must equal the matching base bit. Address bits with a clear mask bit, and address bits 12:0, do not take part in the compare. A valid access that matches the window and whose direction is enabled pulls the chip-select low in the following clock cycle. Register read-back is combinational from the selected register.

Top module: `mem_window_cs`

## Requirements
- R1: After reset both registers read back as 0 and `csN` is high.
- R2: `regSel` = 0 selects the base register and `regSel` = 1 selects the control register. A write updates only the bytes whose `regByteEn` bit is set, where bit b covers data bits 8b+7:8b. `regRdData` always shows the selected register.
- R3: Control bits 31:27 and 23:19 are reserved. Writes to them are dropped and they always read back as 0, so the writable control mask is 0x0707FFFF.
- R4: When control bit 26 (decode enable) is 0, `csN` never goes low.
- R5: Control bit 25 enables the chip-select for write accesses (`accWrite` = 1). When it is 0, matching writes leave `csN` high.
- R6: Control bit 24 enables the chip-select for read accesses (`accWrite` = 0). When it is 0, matching reads leave `csN` high.
- R7: Control bit i (i = 0 to 18) set to 1 requires address bit 13+i to equal base bit 13+i. Set to 0, that address bit is ignored. Address bits 12:0 and base bits 12:0 never affect the match.
- R8: `csN` is registered. It is low for exactly the cycle after each clock edge that samples a qualifying access, so back-to-back qualifying accesses hold it low and it returns high after the last one.
- R9: While `accValid` is 0, `csN` stays high whatever the address and direction inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write request |
| regSel | input | 1 | Register select: 0 base, 1 control |
| regByteEn | input | 4 | Per-byte write enables |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read-back of the selected register |
| accValid | input | 1 | Access address valid |
| accWrite | input | 1 | Access direction: 1 write, 0 read |
| accAddr | input | 32 | Access address |
| csN | output | 1 | Active-low chip-select strobe |

## Verification
The bound checker enforces these rules on every cycle: the reserved control bits stay zero, an invalid or disabled access never gives a strobe, a direction whose qualifier is clear is blocked, and every qualifying access produces a low strobe on the next cycle. Only the bench scenarios can show the other behaviours. These are the byte-lane partial updates and the read-back values, the dropping of reserved bits during a write, how a mix of masked and compared address bits decides hit or miss, and the exact strobe length over back-to-back and idle accesses.

// File: rtl/mwcs_pkg.sv
package mwcs_pkg;
  localparam int ADDR_W   = 32;
  localparam int DATA_W   = 32;
  localparam int BYTES    = DATA_W / 8;
  localparam int MASK_W   = 19;
  localparam int MASK_LSB = ADDR_W - MASK_W;
  localparam int EN_BIT   = 26;
  localparam int WR_BIT   = 25;
  localparam int RD_BIT   = 24;
  localparam logic [DATA_W-1:0] CTRL_KEEP =
      DATA_W'((64'd1 << MASK_W) - 64'd1) |
      (DATA_W'(1) << EN_BIT) | (DATA_W'(1) << WR_BIT) | (DATA_W'(1) << RD_BIT);

  typedef struct packed {
    logic [BYTES-1:0] baseWe;
    logic [BYTES-1:0] ctrlWe;
    logic             accRd;
    logic             accWr;
  } strobe_t;
endpackage

// File: rtl/mwcs_ctrl.sv
module mwcs_ctrl
  import mwcs_pkg::*;
(
  input  logic             regWrEn,
  input  logic             regSel,
  input  logic [BYTES-1:0] regByteEn,
  input  logic             accValid,
  input  logic             accWrite,
  output strobe_t          stb
);
  always_comb begin
    stb.baseWe = (regWrEn && !regSel) ? regByteEn : '0;
    stb.ctrlWe = (regWrEn &&  regSel) ? regByteEn : '0;
    stb.accWr  = accValid &&  accWrite;
    stb.accRd  = accValid && !accWrite;
  end
endmodule

// File: rtl/mwcs_datapath.sv
module mwcs_datapath
  import mwcs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              regSel,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [ADDR_W-1:0] accAddr,
  output logic [DATA_W-1:0] regRdData,
  output logic [DATA_W-1:0] baseQ,
  output logic [DATA_W-1:0] ctrlQ,
  output logic              csN
);
  for (genvar b = 0; b < BYTES; b++) begin : gByte
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseQ[b*8 +: 8] <= '0;
        ctrlQ[b*8 +: 8] <= '0;
      end else begin
        if (stb.baseWe[b]) baseQ[b*8 +: 8] <= regWrData[b*8 +: 8];
        if (stb.ctrlWe[b]) ctrlQ[b*8 +: 8] <= regWrData[b*8 +: 8] & CTRL_KEEP[b*8 +: 8];
      end
    end
  end

  logic [ADDR_W-1:0] cmpMask;
  logic              hit;
  logic              qualify;

  always_comb begin
    cmpMask = {ctrlQ[MASK_W-1:0], {MASK_LSB{1'b0}}};
    hit     = ((accAddr ^ baseQ) & cmpMask) == '0;
    qualify = ctrlQ[EN_BIT] && hit &&
              ((stb.accWr && ctrlQ[WR_BIT]) || (stb.accRd && ctrlQ[RD_BIT]));
    regRdData = regSel ? ctrlQ : baseQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) csN <= 1'b1;
    else       csN <= !qualify;
  end
endmodule

// File: rtl/mem_window_cs.sv
module mem_window_cs
  import mwcs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [BYTES-1:0]  regByteEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [ADDR_W-1:0] accAddr,
  output logic              csN
);
  strobe_t           stb;
  logic [DATA_W-1:0] baseQ;
  logic [DATA_W-1:0] ctrlQ;

  mwcs_ctrl uCtrl (
    .regWrEn(regWrEn), .regSel(regSel), .regByteEn(regByteEn),
    .accValid(accValid), .accWrite(accWrite), .stb(stb)
  );

  mwcs_datapath uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .regSel(regSel),
    .regWrData(regWrData), .accAddr(accAddr), .regRdData(regRdData),
    .baseQ(baseQ), .ctrlQ(ctrlQ), .csN(csN)
  );
endmodule

// File: rtl/mem_window_cs_chk.sv
module mem_window_cs_chk
  import mwcs_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              accValid,
  input logic              accWrite,
  input logic [ADDR_W-1:0] accAddr,
  input logic [DATA_W-1:0] baseQ,
  input logic [DATA_W-1:0] ctrlQ,
  input logic              csN
);
  logic inWindow;
  always_comb begin
    inWindow = 1'b1;
    for (int i = 0; i < MASK_W; i++)
      if (ctrlQ[i] && (accAddr[MASK_LSB+i] != baseQ[MASK_LSB+i])) inWindow = 1'b0;
  end

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ & ~CTRL_KEEP) == '0); // R3
  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlQ[EN_BIT] |=> csN); // R4
  AST_WRITE_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accWrite && !ctrlQ[WR_BIT]) |=> csN); // R5
  AST_READ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !accWrite && !ctrlQ[RD_BIT]) |=> csN); // R6
  AST_HIT_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && ctrlQ[EN_BIT] && inWindow &&
     (accWrite ? ctrlQ[WR_BIT] : ctrlQ[RD_BIT])) |=> !csN); // R8
  AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |=> csN); // R9
endmodule

bind mem_window_cs mem_window_cs_chk uChk (
  .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
  .accAddr(accAddr), .baseQ(baseQ), .ctrlQ(ctrlQ), .csN(csN)
);

// File: tb/mem_window_cs_test.sv
module mem_window_cs_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regSel = 1'b0;
  logic [3:0]  regByteEn = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        accValid = 1'b0;
  logic        accWrite = 1'b0;
  logic [31:0] accAddr = '0;
  logic        csN;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  mem_window_cs uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regByteEn(regByteEn), .regWrData(regWrData), .regRdData(regRdData),
    .accValid(accValid), .accWrite(accWrite), .accAddr(accAddr), .csN(csN)
  );

  task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(logic sel, logic [31:0] data, logic [3:0] be);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = data; regByteEn = be;
    @(negedge clk);
    regWrEn = 1'b0; regByteEn = '0;
  endtask

  task automatic readReg(string req, logic sel, logic [31:0] exp);
    @(negedge clk);
    regSel = sel;
    #1 check32(req, regRdData, exp);
  endtask

  // one access cycle; csN checked in the following cycle
  task automatic access(string req, logic v, logic wr, logic [31:0] addr, logic expCs);
    @(negedge clk);
    accValid = v; accWrite = wr; accAddr = addr;
    @(negedge clk);
    accValid = 1'b0;
    check32(req, {31'd0, csN}, {31'd0, !expCs});
  endtask

  task automatic testReset();
    readReg("R1 base", 1'b0, 32'h0);
    readReg("R1 ctrl", 1'b1, 32'h0);
    check32("R1 csN", {31'd0, csN}, 32'd1);
  endtask

  task automatic testByteEnables();
    regWrite(1'b0, 32'hAABBCCDD, 4'b0101);
    readReg("R2 partial", 1'b0, 32'h00BB00DD);
    regWrite(1'b0, 32'h11223344, 4'b1000);
    readReg("R2 top byte", 1'b0, 32'h11BB00DD);
    regWrite(1'b0, 32'h12346000, 4'b1111);
    readReg("R2 full", 1'b0, 32'h12346000);
  endtask

  task automatic testReserved();
    regWrite(1'b1, 32'hFFFFFFFF, 4'b1111);
    readReg("R3 reserved", 1'b1, 32'h0707FFFF);
  endtask

  task automatic testDisable();
    regWrite(1'b1, 32'h0307FFFF, 4'b1111);
    access("R4 disabled write", 1'b1, 1'b1, 32'h12346000, 1'b0);
    access("R4 disabled read",  1'b1, 1'b0, 32'h12346000, 1'b0);
  endtask

  task automatic testWriteOnly();
    regWrite(1'b1, 32'h0607FFFF, 4'b1111);
    access("R5 write hit", 1'b1, 1'b1, 32'h12346000, 1'b1);
    access("R6 read blocked", 1'b1, 1'b0, 32'h12346000, 1'b0);
  endtask

  task automatic testReadOnly();
    regWrite(1'b1, 32'h0507FFFF, 4'b1111);
    access("R6 read hit", 1'b1, 1'b0, 32'h12346000, 1'b1);
    access("R5 write blocked", 1'b1, 1'b1, 32'h12346000, 1'b0);
  endtask

  task automatic testMask();
    // compare address bits 31:24 only (mask bits 18:11)
    regWrite(1'b1, 32'h0707F800, 4'b1111);
    access("R7 ignored bits differ", 1'b1, 1'b0, 32'h12FFFFFF, 1'b1);
    access("R7 compared bit differs", 1'b1, 1'b0, 32'h13346000, 1'b0);
    // full mask, low 13 bits differ
    regWrite(1'b1, 32'h0707FFFF, 4'b1111);
    access("R7 low bits ignored", 1'b1, 1'b1, 32'h12347FFF, 1'b1);
    access("R7 bit13 compared", 1'b1, 1'b1, 32'h12344000, 1'b0);
  endtask

  task automatic testTiming();
    @(negedge clk);
    accValid = 1'b1; accWrite = 1'b0; accAddr = 32'h12346000;
    @(negedge clk);
    check32("R8 first strobe", {31'd0, csN}, 32'd0);
    @(negedge clk);
    accValid = 1'b0;
    check32("R8 back-to-back", {31'd0, csN}, 32'd0);
    @(negedge clk);
    check32("R8 release", {31'd0, csN}, 32'd1);
    access("R9 not valid", 1'b0, 1'b0, 32'h12346000, 1'b0);
    access("R9 not valid write", 1'b0, 1'b1, 32'h12346000, 1'b0);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testReset();
    testByteEnables();
    testReserved();
    testDisable();
    testWriteOnly();
    testReadOnly();
    testMask();
    testTiming();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule